// File: doc/BRIEF.md
# Setup Message Sequence Parser

This block takes a one-way stream of setup messages that a coordinating server sends to one client. It checks the stream and extracts what the client needs from it. Every message is a signed 64-bit number. It arrives one byte per cycle, least significant byte first, together with a valid strobe and a flag that says whether a descriptor comes with the message.

The parser checks the fixed opening steps in order:

- a protocol version of zero;
- the client's own identifier;
- the shared-memory marker, which is the value -1 with a descriptor.

After the opening, the parser follows runs of repeated identifiers. Within a run, the position of each repeat gives its vector number. A run of some other peer's identifier gives that peer's count of outgoing vectors, and the parser reports it on a peer-table update port. A run of the client's own identifier gives the count of incoming vectors. Every count is capped at a configured maximum.

Once the own-identifier run has started, setup is complete. From then on, a peer identifier with a descriptor is a connect notice and a peer identifier without one is a disconnect notice. A message that breaks the rules raises a sticky close flag. After that, the parser takes no action on further input until reset.

Top module: `setup_msg_parser`

## Requirements
- R1: A message is eight bytes accepted on `in_valid`, least significant first. The descriptor flag is taken from the eighth byte. The message's effect shows on the outputs right after the first rising edge that follows the edge accepting its eighth byte.
- R2: The first message must be the value zero. Any other value raises `closed`.
- R3: The second message is the own identifier. A value from 0 to 65535 is presented on `own_id` with `own_id_valid` high. Any value outside that range raises `closed`.
- R4: The third message must be -1 with the descriptor flag set. Anything else raises `closed`.
- R5: After the third message, a peer identifier (0..65535, not the own identifier) with a descriptor produces a one-cycle `upd_valid` pulse carrying that peer and a count. The count is the number of consecutive repeats of that peer, saturating at NUM_VEC. A change of identifier starts the count again at 1.
- R6: Each own identifier with a descriptor after the third message raises `setup_done`, which stays high until reset. It also increments `own_vec_count`, which saturates at NUM_VEC. These messages produce no update pulse.
- R7: While `setup_done` is low, a peer identifier without a descriptor raises `closed`.
- R8: While `setup_done` is high, a peer identifier without a descriptor produces an update pulse for that peer with count 0. A later connect of that peer starts again at count 1.
- R9: After the third message, the following raise `closed`: the value -1, any negative value, any value above 65535, or the own identifier without a descriptor.
- R10: Once `closed` is high it stays high until reset. No update pulse occurs, and `own_id_valid`, `setup_done` and `own_vec_count` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Message byte, least significant first |
| in_desc | input | 1 | Descriptor attached (sampled with the eighth byte) |
| own_id | output | 16 | Learned own identifier |
| own_id_valid | output | 1 | Own identifier has been received |
| own_vec_count | output | $clog2(NUM_VEC+1) | Connected incoming vectors |
| setup_done | output | 1 | Own identifier run has begun |
| closed | output | 1 | Sticky protocol error / close |
| upd_valid | output | 1 | Peer-table update pulse |
| upd_peer | output | 16 | Peer identifier of the update |
| upd_count | output | $clog2(NUM_VEC+1) | New outgoing vector count for that peer |

## Verification
Saturation is the hardest state to reach. It needs a long run of one identical identifier after a correct opening, and the run must end right at NUM_VEC and beyond it. The bench sweeps every pairing of peer-run length and own-run length from zero to two past the cap, each after a fresh reset and opening. This gives the value of `setup_done` and both counts for every length. Disconnect handling is reached only after the own run has started, so the bench first completes setup and then interleaves connect, disconnect and reconnect notices.

// File: rtl/smp_pkg.sv
package smp_pkg;
    localparam int MSG_BYTES = 8;
    localparam int MSG_W     = 8 * MSG_BYTES;
    localparam int ID_W      = 16;
    localparam int BCNT_W    = $clog2(MSG_BYTES);

    typedef enum logic [2:0] {
        PH_VER,
        PH_ID,
        PH_SHM,
        PH_RUN,
        PH_CLOSED
    } phase_e;
endpackage

// File: rtl/smp_assembler.sv
module smp_assembler
    import smp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             in_desc,
    output logic             msg_valid,
    output logic [MSG_W-1:0] msg_value,
    output logic             msg_desc
);
    typedef struct packed {
        logic [BCNT_W-1:0] cnt;
        logic [MSG_W-1:0]  shreg;
        logic              mv;
        logic              fd;
    } asm_t;

    asm_t s_q, s_d;

    always_comb begin
        s_d    = s_q;
        s_d.mv = 1'b0;
        if (in_valid) begin
            s_d.shreg[8*s_q.cnt +: 8] = in_byte;
            if (s_q.cnt == BCNT_W'(MSG_BYTES - 1)) begin
                s_d.cnt = '0;
                s_d.mv  = 1'b1;
                s_d.fd  = in_desc;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign msg_valid = s_q.mv;
    assign msg_value = s_q.shreg;
    assign msg_desc  = s_q.fd;
endmodule

// File: rtl/smp_classifier.sv
module smp_classifier
    import smp_pkg::*;
(
    input  logic [MSG_W-1:0] value,
    input  logic [ID_W-1:0]  own_id,
    output logic             is_zero,
    output logic             is_neg1,
    output logic             is_id,
    output logic             is_own,
    output logic [ID_W-1:0]  id
);
    always_comb begin
        is_zero = (value == '0);
        is_neg1 = (value == '1);
        is_id   = (value[MSG_W-1:ID_W] == '0);
        id      = value[ID_W-1:0];
        is_own  = is_id && (id == own_id);
    end
endmodule

// File: rtl/setup_msg_parser.sv
module setup_msg_parser
    import smp_pkg::*;
#(
    parameter int NUM_VEC = 4,
    localparam int CW = $clog2(NUM_VEC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [7:0]      in_byte,
    input  logic            in_desc,
    output logic [ID_W-1:0] own_id,
    output logic            own_id_valid,
    output logic [CW-1:0]   own_vec_count,
    output logic            setup_done,
    output logic            closed,
    output logic            upd_valid,
    output logic [ID_W-1:0] upd_peer,
    output logic [CW-1:0]   upd_count
);
    typedef struct packed {
        phase_e          phase;
        logic [ID_W-1:0] own_id;
        logic            own_valid;
        logic            done;
        logic            run_act;
        logic [ID_W-1:0] run_peer;
        logic [CW-1:0]   run_cnt;
        logic [CW-1:0]   own_cnt;
        logic            upd_v;
        logic [ID_W-1:0] upd_peer;
        logic [CW-1:0]   upd_cnt;
    } prs_t;

    prs_t s_q, s_d;

    logic             msg_valid;
    logic [MSG_W-1:0] msg_value;
    logic             msg_desc;
    logic             c_zero, c_neg1, c_id, c_own;
    logic [ID_W-1:0]  c_idv;

    smp_assembler u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .in_desc   (in_desc),
        .msg_valid (msg_valid),
        .msg_value (msg_value),
        .msg_desc  (msg_desc)
    );

    smp_classifier u_cls (
        .value   (msg_value),
        .own_id  (s_q.own_id),
        .is_zero (c_zero),
        .is_neg1 (c_neg1),
        .is_id   (c_id),
        .is_own  (c_own),
        .id      (c_idv)
    );

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
        return (v == CW'(NUM_VEC)) ? v : v + 1'b1;
    endfunction

    always_comb begin
        s_d       = s_q;
        s_d.upd_v = 1'b0;
        if (msg_valid) begin
            unique case (s_q.phase)
                PH_VER: s_d.phase = c_zero ? PH_ID : PH_CLOSED;
                PH_ID: begin
                    if (c_id) begin
                        s_d.own_id    = c_idv;
                        s_d.own_valid = 1'b1;
                        s_d.phase     = PH_SHM;
                    end else begin
                        s_d.phase = PH_CLOSED;
                    end
                end
                PH_SHM: s_d.phase = (c_neg1 && msg_desc) ? PH_RUN : PH_CLOSED;
                PH_RUN: begin
                    if (!c_id) begin
                        s_d.phase = PH_CLOSED;
                    end else if (c_own) begin
                        if (!msg_desc) begin
                            s_d.phase = PH_CLOSED;
                        end else begin
                            s_d.done    = 1'b1;
                            s_d.own_cnt = sat_inc(s_q.own_cnt);
                            s_d.run_act = 1'b0;
                        end
                    end else if (msg_desc) begin
                        if (s_q.run_act && s_q.run_peer == c_idv)
                            s_d.run_cnt = sat_inc(s_q.run_cnt);
                        else
                            s_d.run_cnt = CW'(1);
                        s_d.run_act  = 1'b1;
                        s_d.run_peer = c_idv;
                        s_d.upd_v    = 1'b1;
                        s_d.upd_peer = c_idv;
                        s_d.upd_cnt  = s_d.run_cnt;
                    end else if (s_q.done) begin
                        s_d.run_act  = 1'b0;
                        s_d.upd_v    = 1'b1;
                        s_d.upd_peer = c_idv;
                        s_d.upd_cnt  = '0;
                    end else begin
                        s_d.phase = PH_CLOSED;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{phase: PH_VER, default: '0};
        else        s_q <= s_d;
    end

    assign own_id        = s_q.own_id;
    assign own_id_valid  = s_q.own_valid;
    assign own_vec_count = s_q.own_cnt;
    assign setup_done    = s_q.done;
    assign closed        = (s_q.phase == PH_CLOSED);
    assign upd_valid     = s_q.upd_v;
    assign upd_peer      = s_q.upd_peer;
    assign upd_count     = s_q.upd_cnt;
endmodule

// File: rtl/setup_msg_parser_checker.sv
module setup_msg_parser_checker
    import smp_pkg::*;
#(
    parameter int NUM_VEC = 4,
    localparam int CW = $clog2(NUM_VEC + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [7:0]      in_byte,
    input logic            in_desc,
    input logic [ID_W-1:0] own_id,
    input logic            own_id_valid,
    input logic [CW-1:0]   own_vec_count,
    input logic            setup_done,
    input logic            closed,
    input logic            upd_valid,
    input logic [ID_W-1:0] upd_peer,
    input logic [CW-1:0]   upd_count
);
    assert_upd_spaced_R1: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> !upd_valid);

    assert_setup_has_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
        setup_done |-> own_id_valid);

    assert_upd_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (upd_count <= CW'(NUM_VEC)) && own_id_valid && (upd_peer != own_id));

    assert_own_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        own_vec_count <= CW'(NUM_VEC));

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        setup_done |=> setup_done);

    assert_disc_after_setup_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_count == '0) |-> setup_done);

    assert_closed_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        closed |=> closed && !upd_valid && $stable(own_vec_count) && $stable(setup_done));
endmodule

bind setup_msg_parser setup_msg_parser_checker #(.NUM_VEC(NUM_VEC)) u_chk (.*);

// File: tb/setup_msg_parser_bench.sv
module setup_msg_parser_bench;
    localparam int NV = 4;
    localparam int CW = $clog2(NV + 1);
    localparam logic [63:0] NEG1 = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = '0;
    logic          in_desc = 1'b0;
    logic [15:0]   own_id;
    logic          own_id_valid;
    logic [CW-1:0] own_vec_count;
    logic          setup_done;
    logic          closed;
    logic          upd_valid;
    logic [15:0]   upd_peer;
    logic [CW-1:0] upd_count;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    setup_msg_parser #(.NUM_VEC(NV)) u_setup_msg_parser (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drives eight bytes, then waits until the result is visible (sampled at a negedge)
    task automatic send(input logic [63:0] v, input logic d);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = v[8*i +: 8];
            in_desc  = d;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_desc  = 1'b0;
        @(negedge clk);
    endtask

    task automatic opening(input logic [15:0] id);
        send(64'd0, 1'b0);
        send({48'd0, id}, 1'b0);
        send(NEG1, 1'b1);
    endtask

    function automatic int smin(input int a);
        return (a > NV) ? NV : a;
    endfunction

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk("R10 reset closed", 32'(closed), 0);
        chk("R6 reset done", 32'(setup_done), 0);
        chk("R3 reset idv", 32'(own_id_valid), 0);
        chk("R5 reset upd", 32'(upd_valid), 0);
        chk("R6 reset cnt", 32'(own_vec_count), 0);

        // R1 R3: little-endian identifier
        send(64'd0, 1'b0);
        chk("R2 zero version ok", 32'(closed), 0);
        send(64'h0000_0000_0000_1234, 1'b0);
        chk("R1 R3 own id", 32'(own_id), 32'h1234);
        chk("R3 id valid", 32'(own_id_valid), 1);
        send(NEG1, 1'b1);
        chk("R4 shm ok", 32'(closed), 0);

        // sweep of peer-run and own-run lengths
        for (int k = 0; k <= NV + 2; k++) begin
            for (int m = 0; m <= NV + 2; m++) begin
                do_reset();
                opening(16'd5);
                for (int i = 1; i <= k; i++) begin
                    send(64'd7, 1'b1);
                    chk("R5 upd valid", 32'(upd_valid), 1);
                    chk("R5 upd peer", 32'(upd_peer), 7);
                    chk("R5 upd count", 32'(upd_count), 32'(smin(i)));
                    chk("R6 not done", 32'(setup_done), 0);
                end
                for (int i = 1; i <= m; i++) begin
                    send(64'd5, 1'b1);
                    chk("R6 no upd", 32'(upd_valid), 0);
                end
                chk("R6 own cnt", 32'(own_vec_count), 32'(smin(m)));
                chk("R6 done", 32'(setup_done), (m > 0) ? 1 : 0);
                chk("R9 not closed", 32'(closed), 0);
            end
        end

        // R5 restart on a different peer, R8 disconnect / reconnect
        do_reset();
        opening(16'd5);
        send(64'd3, 1'b1);
        send(64'd3, 1'b1);
        send(64'd4, 1'b1);
        chk("R5 restart count", 32'(upd_count), 1);
        send(64'd5, 1'b1);
        for (int i = 1; i <= NV + 1; i++) send(64'd9, 1'b1);
        chk("R5 runtime sat", 32'(upd_count), NV);
        send(64'd9, 1'b0);
        chk("R8 disc valid", 32'(upd_valid), 1);
        chk("R8 disc peer", 32'(upd_peer), 9);
        chk("R8 disc count", 32'(upd_count), 0);
        send(64'd9, 1'b1);
        chk("R8 reconnect", 32'(upd_count), 1);
        send(64'd65535, 1'b1);
        chk("R5 max id", 32'(upd_peer), 16'hFFFF);

        // error cases
        do_reset(); send(64'd1, 1'b0);
        chk("R2 bad version", 32'(closed), 1);
        do_reset(); send(64'd0, 1'b0); send(64'd65536, 1'b0);
        chk("R3 id range", 32'(closed), 1);
        do_reset(); send(64'd0, 1'b0); send(64'd5, 1'b0); send(NEG1, 1'b0);
        chk("R4 shm no desc", 32'(closed), 1);
        do_reset(); send(64'd0, 1'b0); send(64'd5, 1'b0); send(64'd2, 1'b1);
        chk("R4 shm wrong val", 32'(closed), 1);
        do_reset(); opening(16'd5); send(64'd7, 1'b0);
        chk("R7 disc before setup", 32'(closed), 1);
        do_reset(); opening(16'd5); send(NEG1, 1'b1);
        chk("R9 extra marker", 32'(closed), 1);
        do_reset(); opening(16'd5); send(64'hFFFF_FFFF_FFFF_FFFE, 1'b1);
        chk("R9 negative", 32'(closed), 1);
        do_reset(); opening(16'd5); send(64'h1_0003, 1'b1);
        chk("R9 big value", 32'(closed), 1);
        do_reset(); opening(16'd5); send(64'd5, 1'b0);
        chk("R9 own no desc", 32'(closed), 1);

        // R10 closed ignores input
        do_reset();
        send(64'd2, 1'b0);
        send(64'd0, 1'b0);
        send(64'd5, 1'b0);
        chk("R10 idv held", 32'(own_id_valid), 0);
        send(NEG1, 1'b1);
        send(64'd5, 1'b1);
        chk("R10 no done", 32'(setup_done), 0);
        chk("R10 own cnt held", 32'(own_vec_count), 0);
        send(64'd7, 1'b1);
        chk("R10 no upd", 32'(upd_valid), 0);
        chk("R10 still closed", 32'(closed), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule